// File: doc/BRIEF.md
# Banked 64-bit Comparator Global Timer

A memory-mapped timer built around one free-running 64-bit up-counter that all requesting processors share. Each of `NUM_REQ` requesters owns a private bank: a 64-bit comparator, compare/interrupt/auto-increment enables, a sticky event flag and a 32-bit auto-increment step. A 32-bit register port, together with a requester-ID input, picks which bank an access reaches. The counter run bit and the prescaler are shared. Each requester gets its own level interrupt.

A requester programs a comparator and enables compare. When the counter reaches or passes that value, the requester's event flag sets. If its interrupt enable is set, its interrupt line rises. When auto-increment is enabled, every match adds the step to the comparator, which gives periodic events. The counter is read as two 32-bit halves with no snapshot latch, so software must detect a carry between the two reads itself.

Top module: `banked_gtimer`

## Requirements
- R1: After reset the counter, the prescaler, every enable bit, every comparator, every step and every event flag are zero, and all interrupt outputs are low.
- R2: The counter holds its value while the shared run bit (control bit 0, offset 0x08) is clear. With the run bit set and a prescale of 0, it advances by one on every clock.
- R3: With the run bit set and prescale value P (control bits [15:8]), the counter advances once every P+1 clocks.
- R4: The low counter word reads at offset 0x00 and the high word at 0x04. A carry from the low word into the high word is visible at once. Writes to either half load the counter only while the run bit is clear, and are ignored while it runs.
- R5: When a requester's compare enable (control bit 1) is set and the counter is greater than or equal to its comparator (low word 0x10, high word 0x14), that requester's event flag (bit 0 of offset 0x0C) reads 1 from the following clock. With compare disabled no flag is set.
- R6: The event flag stays set until its requester writes 1 to bit 0 of offset 0x0C. Writing 0 has no effect. A clearing write made while the counter is still at or past the comparator, with compare enabled, leaves the flag set.
- R7: Each requester's interrupt output is high exactly when its event flag and its interrupt enable (control bit 2) are both set.
- R8: With auto-increment (control bit 3) enabled, each match adds the step at offset 0x18 to that requester's comparator on the same clock that sets the flag. A frozen counter F therefore leaves the comparator at the first value of the form start + k·step that is above F.
- R9: Comparator, step, flag and control bits 1–3 are private per requester: an access with ID n reads and writes only bank n. The run bit and the prescaler are shared, so a control write from any requester updates them.
- R10: A comparator-half or step write is visible on read-back from the next clock. A register write overrides a concurrent auto-increment.
- R11: Offsets outside the map read as 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_id | input | ID_W | Requester ID that selects the private bank |
| acc_addr | input | 5 | Byte offset of the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from address and ID while a read is valid, else 0 |
| irq | output | NUM_REQ | Level interrupt for each requester |

## Verification
Read data is combinational from the current state. Every register write and every match takes effect on the clock edge that ends its cycle. A flag set by a match therefore shows one clock after the counter reaches the comparator, and a write shows on a read issued the following cycle. The bench drives each access just after a falling edge and samples `acc_rdata` and `irq` 1 ns later. A cycle model advanced on each rising edge holds the expected state. Counter spacing checks compare two reads taken a known number of edges apart and choose spans that are whole multiples of the prescale period, so the result does not depend on the prescaler's phase.

// File: rtl/gtimer_pkg.sv
// Package: shared register offsets, control-field positions and the
// per-requester control bit type of the banked global timer.
// Assumes a 32-bit data path and byte offsets on a 5-bit address.
package gtimer_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFF_CNT_LO = 5'h00;
    localparam logic [REG_AW-1:0] OFF_CNT_HI = 5'h04;
    localparam logic [REG_AW-1:0] OFF_CTRL   = 5'h08;
    localparam logic [REG_AW-1:0] OFF_STAT   = 5'h0C;
    localparam logic [REG_AW-1:0] OFF_CMP_LO = 5'h10;
    localparam logic [REG_AW-1:0] OFF_CMP_HI = 5'h14;
    localparam logic [REG_AW-1:0] OFF_STEP   = 5'h18;

    localparam int CTL_RUN     = 0;
    localparam int CTL_CMP     = 1;
    localparam int CTL_IRQ     = 2;
    localparam int CTL_AUTO    = 3;
    localparam int CTL_PRE_LSB = 8;

    typedef struct packed {
        logic auto_en;
        logic irq_en;
        logic cmp_en;
    } bank_ctl_t;

endpackage

// File: rtl/gtimer_regdec.sv
// Module: gtimer_regdec
// Turns one register access into write strobes: shared strobes for the
// control and counter halves, and per-bank strobes steered by the
// requester ID. Assumes IDs at or above NUM_REQ reach no bank.
module gtimer_regdec
    import gtimer_pkg::*;
#(
    parameter int NUM_REQ = 2,
    parameter int ID_W    = 1
) (
    input  logic               acc_en,
    input  logic               acc_wr,
    input  logic [ID_W-1:0]    acc_id,
    input  logic [REG_AW-1:0]  acc_addr,
    output logic               id_ok,
    output logic               wr_ctl_shared,
    output logic               wr_cnt_lo,
    output logic               wr_cnt_hi,
    output logic [NUM_REQ-1:0] wr_ctl,
    output logic [NUM_REQ-1:0] wr_stat,
    output logic [NUM_REQ-1:0] wr_cmp_lo,
    output logic [NUM_REQ-1:0] wr_cmp_hi,
    output logic [NUM_REQ-1:0] wr_step
);

    logic wr_any;

    // Purpose: qualify a write and range-check the requester ID.
    always_comb begin
        wr_any = acc_en && acc_wr;
        id_ok  = (32'(acc_id) < NUM_REQ);
    end

    // Purpose: decode writes to registers that every requester shares.
    always_comb begin
        wr_ctl_shared = wr_any && id_ok && (acc_addr == OFF_CTRL);
        wr_cnt_lo     = wr_any && (acc_addr == OFF_CNT_LO);
        wr_cnt_hi     = wr_any && (acc_addr == OFF_CNT_HI);
    end

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_bank_sel
        logic hit;
        // Purpose: steer the private-register strobes to bank i only.
        always_comb begin
            hit          = wr_any && id_ok && (32'(acc_id) == i);
            wr_ctl[i]    = hit && (acc_addr == OFF_CTRL);
            wr_stat[i]   = hit && (acc_addr == OFF_STAT);
            wr_cmp_lo[i] = hit && (acc_addr == OFF_CMP_LO);
            wr_cmp_hi[i] = hit && (acc_addr == OFF_CMP_HI);
            wr_step[i]   = hit && (acc_addr == OFF_STEP);
        end
    end

endmodule

// File: rtl/gtimer_counter.sv
// Module: gtimer_counter
// Holds the shared run bit and prescaler and the free-running counter.
// The counter ticks once every (prescale+1) clocks while running and
// loads either half only while stopped. No snapshot latch: reads
// see live bits.
module gtimer_counter
    import gtimer_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int PRE_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic              run,
    output logic [PRE_W-1:0]  presc,
    output logic [CNT_W-1:0]  count
);

    localparam int HI_W = CNT_W - DATA_W;

    logic [PRE_W-1:0] pre_cnt;
    logic             tick;

    // Purpose: latch the shared run bit and prescale field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            presc <= '0;
        end else if (wr_ctl) begin
            run   <= wdata[CTL_RUN];
            presc <= wdata[CTL_PRE_LSB +: PRE_W];
        end
    end

    // Purpose: mark the clock on which the counter advances.
    always_comb tick = run && (pre_cnt >= presc);

    // Purpose: divide the clock by (prescale+1) while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) pre_cnt <= '0;
        else                        pre_cnt <= pre_cnt + 1'b1;
    end

    // Purpose: advance the counter, or load a half while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end else if (!run) begin
            if (ld_lo) count[DATA_W-1:0]     <= wdata;
            if (ld_hi) count[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        end
    end

endmodule

// File: rtl/gtimer_bank.sv
// Module: gtimer_bank
// One requester's private comparator bank: enables, comparator,
// auto-increment step and sticky event flag. A match is compare-enabled
// and count >= comparator. A match outranks a clearing write, and a
// register write outranks auto-increment.
module gtimer_bank
    import gtimer_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic              wr_ctl,
    input  logic              wr_stat,
    input  logic              wr_cmp_lo,
    input  logic              wr_cmp_hi,
    input  logic              wr_step,
    input  logic [DATA_W-1:0] wdata,
    output bank_ctl_t         ctl,
    output logic [CNT_W-1:0]  cmp,
    output logic [DATA_W-1:0] step,
    output logic              flag,
    output logic              irq
);

    localparam int HI_W = CNT_W - DATA_W;

    logic match;

    // Purpose: detect that the counter has reached this comparator.
    always_comb match = ctl.cmp_en && (count >= cmp);

    // Purpose: hold the private enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_ctl) begin
            ctl.cmp_en  <= wdata[CTL_CMP];
            ctl.irq_en  <= wdata[CTL_IRQ];
            ctl.auto_en <= wdata[CTL_AUTO];
        end
    end

    // Purpose: load a comparator half, else step it after a match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp <= '0;
        else if (wr_cmp_lo)
            cmp[DATA_W-1:0] <= wdata;
        else if (wr_cmp_hi)
            cmp[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        else if (match && ctl.auto_en)
            cmp <= cmp + {{HI_W{1'b0}}, step};
    end

    // Purpose: hold the auto-increment step.
    always_ff @(posedge clk) begin
        if (!rst_n)       step <= '0;
        else if (wr_step) step <= wdata;
    end

    // Purpose: set the sticky flag on a match; clear on write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag <= 1'b0;
        else if (match)               flag <= 1'b1;
        else if (wr_stat && wdata[0]) flag <= 1'b0;
    end

    // Purpose: gate the flag onto the level interrupt.
    always_comb irq = flag && ctl.irq_en;

endmodule

// File: rtl/banked_gtimer.sv
// Module: banked_gtimer (top)
// Shared 64-bit counter compared against NUM_REQ private comparator
// banks, with a 32-bit register port selected by requester ID.
// Assumes a single clock domain and a combinational read path.
module banked_gtimer
    import gtimer_pkg::*;
#(
    parameter  int NUM_REQ = 2,
    parameter  int CNT_W   = 64,
    parameter  int PRE_W   = 8,
    localparam int DATA_W  = CNT_W / 2,
    localparam int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               acc_wr,
    input  logic [ID_W-1:0]    acc_id,
    input  logic [REG_AW-1:0]  acc_addr,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  acc_rdata,
    output logic [NUM_REQ-1:0] irq
);

    logic               id_ok, wr_ctl_shared, wr_cnt_lo, wr_cnt_hi;
    logic [NUM_REQ-1:0] wr_ctl, wr_stat, wr_cmp_lo, wr_cmp_hi, wr_step;
    logic               run;
    logic [PRE_W-1:0]   presc;
    logic [CNT_W-1:0]   count;

    bank_ctl_t [NUM_REQ-1:0]             ctl_all;
    logic      [NUM_REQ-1:0][CNT_W-1:0]  cmp_all;
    logic      [NUM_REQ-1:0][DATA_W-1:0] step_all;
    logic      [NUM_REQ-1:0]             flag_all;
    logic      [NUM_REQ-1:0]             cen_all, aen_all;

    gtimer_regdec #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_dec (
        .acc_en       (acc_en),
        .acc_wr       (acc_wr),
        .acc_id       (acc_id),
        .acc_addr     (acc_addr),
        .id_ok        (id_ok),
        .wr_ctl_shared(wr_ctl_shared),
        .wr_cnt_lo    (wr_cnt_lo),
        .wr_cnt_hi    (wr_cnt_hi),
        .wr_ctl       (wr_ctl),
        .wr_stat      (wr_stat),
        .wr_cmp_lo    (wr_cmp_lo),
        .wr_cmp_hi    (wr_cmp_hi),
        .wr_step      (wr_step)
    );

    gtimer_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ctl(wr_ctl_shared),
        .ld_lo (wr_cnt_lo),
        .ld_hi (wr_cnt_hi),
        .wdata (acc_wdata),
        .run   (run),
        .presc (presc),
        .count (count)
    );

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_bank
        gtimer_bank #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .count    (count),
            .wr_ctl   (wr_ctl[i]),
            .wr_stat  (wr_stat[i]),
            .wr_cmp_lo(wr_cmp_lo[i]),
            .wr_cmp_hi(wr_cmp_hi[i]),
            .wr_step  (wr_step[i]),
            .wdata    (acc_wdata),
            .ctl      (ctl_all[i]),
            .cmp      (cmp_all[i]),
            .step     (step_all[i]),
            .flag     (flag_all[i]),
            .irq      (irq[i])
        );
        // Purpose: expose enable bits as flat vectors for the checker.
        always_comb begin
            cen_all[i] = ctl_all[i].cmp_en;
            aen_all[i] = ctl_all[i].auto_en;
        end
    end

    bank_ctl_t          sel_ctl;
    logic [CNT_W-1:0]   sel_cmp;
    logic [DATA_W-1:0]  sel_step;
    logic               sel_flag;

    // Purpose: pick the addressed requester's bank for read-back.
    always_comb begin
        sel_ctl  = '0;
        sel_cmp  = '0;
        sel_step = '0;
        sel_flag = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (id_ok && (32'(acc_id) == i)) begin
                sel_ctl  = ctl_all[i];
                sel_cmp  = cmp_all[i];
                sel_step = step_all[i];
                sel_flag = flag_all[i];
            end
        end
    end

    // Purpose: multiplex register contents onto the read data.
    always_comb begin
        acc_rdata = '0;
        if (acc_en && !acc_wr) begin
            unique case (acc_addr)
                OFF_CNT_LO: acc_rdata = count[DATA_W-1:0];
                OFF_CNT_HI: acc_rdata = count[CNT_W-1:DATA_W];
                OFF_CTRL: begin
                    acc_rdata[CTL_RUN]                  = run;
                    acc_rdata[CTL_CMP]                  = sel_ctl.cmp_en;
                    acc_rdata[CTL_IRQ]                  = sel_ctl.irq_en;
                    acc_rdata[CTL_AUTO]                 = sel_ctl.auto_en;
                    acc_rdata[CTL_PRE_LSB +: PRE_W]     = presc;
                end
                OFF_STAT:   acc_rdata[0] = sel_flag;
                OFF_CMP_LO: acc_rdata = sel_cmp[DATA_W-1:0];
                OFF_CMP_HI: acc_rdata = sel_cmp[CNT_W-1:DATA_W];
                OFF_STEP:   acc_rdata = sel_step;
                default:    acc_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gtimer_chk.sv
// Module: gtimer_chk
// Property checker for banked_gtimer, attached with bind. Relates the
// counter, the decoded strobes and each bank's state over time.
module gtimer_chk #(
    parameter int NUM_REQ = 2,
    parameter int CNT_W   = 64,
    parameter int DATA_W  = 32
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             run,
    input logic                             ld_lo,
    input logic                             ld_hi,
    input logic [CNT_W-1:0]                 count,
    input logic [NUM_REQ-1:0]               wr_ctl,
    input logic [NUM_REQ-1:0]               wr_stat,
    input logic [NUM_REQ-1:0]               wr_cmp_lo,
    input logic [NUM_REQ-1:0]               wr_cmp_hi,
    input logic [NUM_REQ-1:0]               wr_step,
    input logic [NUM_REQ-1:0]               cmp_en,
    input logic [NUM_REQ-1:0]               auto_en,
    input logic [NUM_REQ-1:0]               flag,
    input logic [NUM_REQ-1:0][CNT_W-1:0]    cmp,
    input logic [NUM_REQ-1:0][DATA_W-1:0]   step
);

    logic [NUM_REQ-1:0] bank_wr;
    always_comb bank_wr = wr_ctl | wr_stat | wr_cmp_lo | wr_cmp_hi | wr_step;

    // R2: a stopped counter with no load holds its value.
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_lo && !ld_hi) |=> $stable(count));

    // R3: a running counter moves by at most one per clock.
    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

    // R9: one access reaches at most one private bank.
    assert_one_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr));

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_bank_chk
        // R5: a match sets the flag on the next clock.
        assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_en[i] && (count >= cmp[i])) |=> flag[i]);

        // R6: without a status write the flag cannot fall.
        assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !wr_stat[i]) |=> flag[i]);

        // R8: a match with auto-increment adds the step.
        assert_auto_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_en[i] && auto_en[i] && (count >= cmp[i]) && !wr_cmp_lo[i] && !wr_cmp_hi[i])
            |=> (cmp[i] == $past(cmp[i]) + {{(CNT_W-DATA_W){1'b0}}, $past(step[i])}));
    end

endmodule

bind banked_gtimer gtimer_chk #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ld_lo    (wr_cnt_lo),
    .ld_hi    (wr_cnt_hi),
    .count    (count),
    .wr_ctl   (wr_ctl),
    .wr_stat  (wr_stat),
    .wr_cmp_lo(wr_cmp_lo),
    .wr_cmp_hi(wr_cmp_hi),
    .wr_step  (wr_step),
    .cmp_en   (cen_all),
    .auto_en  (aen_all),
    .flag     (flag_all),
    .cmp      (cmp_all),
    .step     (step_all)
);

// File: tb/banked_gtimer_tb.sv
`timescale 1ns/100ps
// Bench for banked_gtimer: directed corner cases with literal expected
// values plus seeded random accesses checked against a cycle model.
module banked_gtimer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_en = 1'b0, b_wr = 1'b0;
    logic [0:0]  b_id = '0;
    logic [4:0]  b_addr = '0;
    logic [31:0] b_wd = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    banked_gtimer u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(b_en), .acc_wr(b_wr), .acc_id(b_id),
        .acc_addr(b_addr), .acc_wdata(b_wd), .acc_rdata(rdata), .irq(irq)
    );

    // Cycle model built from the requirements.
    logic [63:0] m_cnt;
    logic [7:0]  m_pc, m_pre;
    logic        m_run;
    logic [63:0] m_cmp [2];
    logic [31:0] m_inc [2];
    logic        m_cen [2], m_ien [2], m_aen [2], m_flag [2];
    logic        m_tick;
    logic [1:0]  m_match;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_pc = '0; m_pre = '0; m_run = 1'b0;
            for (int i = 0; i < 2; i++) begin
                m_cmp[i] = '0; m_inc[i] = '0; m_cen[i] = 1'b0;
                m_ien[i] = 1'b0; m_aen[i] = 1'b0; m_flag[i] = 1'b0;
            end
        end else begin
            m_tick = m_run && (m_pc >= m_pre);
            for (int i = 0; i < 2; i++) m_match[i] = m_cen[i] && (m_cnt >= m_cmp[i]);
            for (int i = 0; i < 2; i++) begin
                logic w;
                w = b_en && b_wr && (int'(b_id) == i);
                if (m_match[i]) m_flag[i] = 1'b1;
                else if (w && b_addr == 5'h0C && b_wd[0]) m_flag[i] = 1'b0;
                if (w && b_addr == 5'h10) m_cmp[i][31:0] = b_wd;
                else if (w && b_addr == 5'h14) m_cmp[i][63:32] = b_wd;
                else if (m_match[i] && m_aen[i]) m_cmp[i] = m_cmp[i] + {32'd0, m_inc[i]};
                if (w && b_addr == 5'h18) m_inc[i] = b_wd;
                if (w && b_addr == 5'h08) begin
                    m_cen[i] = b_wd[1]; m_ien[i] = b_wd[2]; m_aen[i] = b_wd[3];
                end
            end
            if (m_tick) m_cnt = m_cnt + 1;
            else if (!m_run && b_en && b_wr && b_addr == 5'h00) m_cnt[31:0] = b_wd;
            else if (!m_run && b_en && b_wr && b_addr == 5'h04) m_cnt[63:32] = b_wd;
            if (!m_run || m_tick) m_pc = '0; else m_pc = m_pc + 1;
            if (b_en && b_wr && b_addr == 5'h08) begin
                m_run = b_wd[0]; m_pre = b_wd[15:8];
            end
        end
    end

    function automatic logic [31:0] exp_read(int id, logic [4:0] a);
        case (a)
            5'h00: return m_cnt[31:0];
            5'h04: return m_cnt[63:32];
            5'h08: return {16'd0, m_pre, 4'd0, m_aen[id], m_ien[id], m_cen[id], m_run};
            5'h0C: return {31'd0, m_flag[id]};
            5'h10: return m_cmp[id][31:0];
            5'h14: return m_cmp[id][63:32];
            5'h18: return m_inc[id];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [4:0] a);
        case (a)
            5'h00, 5'h04: return "R4 counter read";
            5'h08:        return "R9 control read";
            5'h0C:        return "R6 status read";
            5'h10, 5'h14: return "R10 comparator read";
            5'h18:        return "R8 step read";
            default:      return "R11 unmapped read";
        endcase
    endfunction

    // Expected comparator after auto-increment settles on a frozen count.
    function automatic logic [31:0] exp_auto(logic [31:0] f, logic [31:0] start, logic [31:0] stp);
        if (f < start) return start;
        return start + stp * ((f - start) / stp + 1);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One bus cycle; compares read data and interrupts with the model.
    task automatic cyc(logic en, logic wr, int id, logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        b_en = en; b_wr = wr; b_id = id[0]; b_addr = a; b_wd = d;
        #1;
        rd = rdata;
        if (en && !wr) check(tag_of(a), rdata, exp_read(id, a));
        check("R7 irq vs model", irq, {m_flag[1] & m_ien[1], m_flag[0] & m_ien[0]});
    endtask

    task automatic wr(int id, logic [4:0] a, logic [31:0] d);
        cyc(1'b1, 1'b1, id, a, d);
    endtask
    task automatic rdr(int id, logic [4:0] a);
        cyc(1'b1, 1'b0, id, a, 32'd0);
    endtask
    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 0, 5'h00, 32'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] a0, f;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rdr(0, 5'h00); check("R1 count lo after reset", rd, 0);
        rdr(0, 5'h04); check("R1 count hi after reset", rd, 0);
        rdr(1, 5'h08); check("R1 control after reset", rd, 0);
        rdr(1, 5'h0C); check("R1 status after reset", rd, 0);
        check("R1 irq after reset", irq, 2'b00);

        // R2: prescale 0 advances each clock
        wr(0, 5'h08, 32'h1);
        rdr(0, 5'h00); a0 = rd; idle(19); rdr(0, 5'h00);
        check("R2 advance per clock", rd - a0, 20);
        // R3: prescale 3 -> one tick per 4 clocks
        wr(1, 5'h08, 32'h0301);
        rdr(0, 5'h08); check("R9 shared run/prescale seen by other ID", rd, 32'h0301);
        rdr(0, 5'h00); a0 = rd; idle(39); rdr(0, 5'h00);
        check("R3 prescale 3 over 40 clocks", rd - a0, 10);
        // R2: stopped counter holds
        wr(0, 5'h08, 32'h0);
        rdr(0, 5'h00); a0 = rd; idle(5); rdr(0, 5'h00);
        check("R2 stopped holds", rd - a0, 0);

        // R4: load while stopped, carry into high word
        wr(0, 5'h00, 32'hFFFF_FFFE); wr(0, 5'h04, 32'h0);
        rdr(0, 5'h04); check("R4 load hi", rd, 0);
        rdr(0, 5'h00); check("R4 load lo", rd, 32'hFFFF_FFFE);
        wr(0, 5'h08, 32'h1);
        rdr(0, 5'h00); check("R4 first cycle after start", rd, 32'hFFFF_FFFE);
        idle(2);
        rdr(0, 5'h04); check("R4 carry into hi", rd, 1);
        rdr(0, 5'h00); check("R4 lo after carry", rd, 2);
        wr(0, 5'h00, 32'h55);
        rdr(0, 5'h00); check("R4 load ignored while running", rd, 4);

        // R5/R6/R7: compare, sticky flag, clear race
        wr(0, 5'h08, 32'h0);
        wr(0, 5'h00, 32'd100); wr(0, 5'h04, 32'd0);
        wr(1, 5'h10, 32'd105); wr(1, 5'h14, 32'd0);
        wr(1, 5'h08, 32'h6);
        rdr(1, 5'h0C); check("R5 no flag below comparator", rd, 0);
        wr(0, 5'h00, 32'd105);
        rdr(1, 5'h0C); check("R5 flag not yet set", rd, 0);
        rdr(1, 5'h0C); check("R5 flag one clock after match", rd, 1);
        check("R7 irq only for requester 1", irq, 2'b10);
        rdr(0, 5'h0C); check("R9 requester 0 flag untouched", rd, 0);
        wr(1, 5'h0C, 32'h1);
        rdr(1, 5'h0C); check("R6 clear loses to live match", rd, 1);
        wr(0, 5'h00, 32'd50);
        wr(1, 5'h0C, 32'h1);
        rdr(1, 5'h0C); check("R6 clear below comparator", rd, 0);
        check("R7 irq low after clear", irq, 2'b00);
        wr(0, 5'h00, 32'd200); idle(1);
        wr(0, 5'h00, 32'd10);
        wr(1, 5'h0C, 32'h0);
        rdr(1, 5'h0C); check("R6 writing 0 keeps flag", rd, 1);
        wr(1, 5'h08, 32'h2);
        rdr(1, 5'h0C); check("R7 flag still set", rd, 1);
        check("R7 irq masked by enable", irq, 2'b00);

        // R10/R9: comparator write visible next clock, private per ID
        wr(1, 5'h10, 32'h1234);
        rdr(1, 5'h10); check("R10 comparator read-back", rd, 32'h1234);
        rdr(0, 5'h10); check("R9 requester 0 comparator private", rd, 0);

        // R11: unmapped offset
        wr(0, 5'h1C, 32'hDEAD_BEEF);
        rdr(0, 5'h1C); check("R11 unmapped reads zero", rd, 0);
        rdr(0, 5'h08); check("R11 control unchanged", rd, 32'h0);

        // R8: auto-increment periodic events on requester 0
        wr(0, 5'h00, 32'd0); wr(0, 5'h04, 32'd0);
        wr(0, 5'h10, 32'd1000); wr(0, 5'h14, 32'd0);
        wr(0, 5'h18, 32'd10);
        rdr(0, 5'h18); check("R10 step read-back", rd, 10);
        wr(0, 5'h08, 32'hB);
        idle(1100);
        wr(0, 5'h08, 32'hA);
        idle(4);
        rdr(0, 5'h00); f = rd;
        rdr(0, 5'h10); check("R8 comparator after periodic steps", rd, exp_auto(f, 1000, 10));
        rdr(0, 5'h0C); check("R8 periodic flag set", rd, 1);
        rdr(1, 5'h10); check("R9 requester 1 comparator unchanged", rd, 32'h1234);

        // Random mix checked against the model (R4-R11)
        for (int k = 0; k < 4000; k++) begin
            int id, sel;
            logic [4:0]  a;
            logic [31:0] d;
            id  = int'($urandom % 2);
            sel = int'($urandom % 8);
            a   = 5'(sel * 4);
            d   = $urandom;
            case (a)
                5'h00: d = $urandom % 4096;
                5'h04, 5'h14: d = ($urandom % 8 == 0) ? 32'd1 : 32'd0;
                5'h08: d = {16'd0, 8'($urandom % 4), 4'd0, 4'($urandom)};
                5'h10: d = $urandom % 8192;
                5'h18: d = $urandom % 64;
                default: ;
            endcase
            if ($urandom % 4 == 0) cyc(1'b0, 1'b0, id, a, d);
            else cyc(1'b1, 1'($urandom % 2), id, a, d);
        end

        summary();
        $finish;
    end

endmodule